// File: doc/BRIEF.md
# Row-Hit-First Request Scheduler with Batched Write Drain

This block picks, one per handshake, the next memory request that a downstream DRAM command generator should turn into commands. Reads are held in one small queue per bank; writes are held in a single shared buffer. Inside a bank, a read that targets the row currently open in that bank overtakes older reads to other rows. Between banks, the candidate with the earliest arrival wins. Each read gets a stamp from a free-running arrival counter when it is accepted, and these stamps are compared to find the oldest.

Reads normally come before writes. Writes wait in the buffer until either no read is pending, or the buffer becomes full. A full buffer starts a batch: a fixed number of back-to-back write issues that reads arriving during the batch cannot interrupt. The block also tracks, per bank, which row the last issue opened, and flags on each issue whether that request hits the open row.

The controller has two named states. `SERVE` gives normal read-first service. `BATCH` gives non-preemptive write drain. There are two transitions. `SERVE -> BATCH` is taken at the end of any cycle that begins with the write buffer full. `BATCH -> SERVE` is taken on the handshake of the last write of the batch.

Top module: `frfcfs_sched`

## Requirements
- R1: After reset, no request is issued, every read queue and the write buffer are empty, both intake ready outputs are high, and no bank has an open row, so the first issue to any bank reports `issue_row_hit` = 0.
- R2: `rd_in_ready` is low exactly when the read queue of the bank on `rd_req_bank` holds RQ_DEPTH entries. `wr_in_ready` is low exactly when the write buffer holds WB_DEPTH entries. Both are judged on the occupancy at the start of the cycle. An accepted request becomes eligible in the following cycle.
- R3: Within one bank, a read whose row equals the bank's open row is selected ahead of any read to another row, even an older one. Among several such row hits, the oldest is selected.
- R4: When reads are chosen, the winner across banks is the bank candidate with the earliest arrival.
- R5: In `SERVE`, with the write buffer not full, a pending read is always issued ahead of buffered writes.
- R6: Writes leave the buffer in their arrival order.
- R7: A cycle in `SERVE` that starts with the write buffer full issues a write. From that write on, exactly WB_DEPTH write issues follow one another, with no read issued between them, whatever reads arrive meanwhile.
- R8: After the last write of a batch, the scheduler serves reads if any are pending; otherwise it keeps draining writes.
- R9: `issue_row_hit` is 1 when the issued request's row equals the row its bank left open. Every handshake makes the issued row the open row of its bank.
- R10: A request leaves the scheduler only on a cycle with `issue_valid` and `issue_ready` both high, and batch progress counts only such cycles. `issue_valid` is high whenever any request is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req_valid | input | 1 | A read request is offered |
| rd_req_bank | input | BANK_W | Bank of the offered read |
| rd_req_row | input | ROW_W | Row of the offered read |
| rd_req_tag | input | TAG_W | Caller's identifier for the read |
| rd_in_ready | output | 1 | The addressed bank queue can take the read |
| wr_req_valid | input | 1 | A write request is offered |
| wr_req_bank | input | BANK_W | Bank of the offered write |
| wr_req_row | input | ROW_W | Row of the offered write |
| wr_req_tag | input | TAG_W | Caller's identifier for the write |
| wr_in_ready | output | 1 | The write buffer can take the write |
| issue_ready | input | 1 | Command generator accepts the selection |
| issue_valid | output | 1 | A selection is presented |
| issue_is_write | output | 1 | 1 = write selected, 0 = read selected |
| issue_bank | output | BANK_W | Bank of the selection |
| issue_row | output | ROW_W | Row of the selection |
| issue_tag | output | TAG_W | Identifier of the selection |
| issue_row_hit | output | 1 | Selection hits its bank's open row |

## Verification
The bench first drives read-only traffic over a narrow set of rows. This brings out both orders: row-hit overtaking within a bank, and age order between banks. Mixed read and write traffic then fills the buffer while reads wait, which separates batch-mode starts from ordinary read-first service. Write-heavy traffic with a stalling `issue_ready` shows that batch length counts handshakes and not cycles. An idle drain with no new reads shows the fall-back to writes once a batch ends. Each cycle's selection, hit flag and intake ready outputs are compared with a behavioural model.

// File: rtl/frs_pkg.sv
package frs_pkg;
    typedef enum logic [0:0] {
        SCH_SERVE = 1'b0,
        SCH_BATCH = 1'b1
    } sch_state_e;
endpackage

// File: rtl/frs_bank_queue.sv
module frs_bank_queue #(
    parameter int DEPTH = 4,
    parameter int ROW_W = 8,
    parameter int TAG_W = 8,
    parameter int TS_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [ROW_W-1:0] push_row,
    input  logic [TAG_W-1:0] push_tag,
    input  logic [TS_W-1:0]  push_ts,
    input  logic             pop,
    input  logic             open_vld,
    input  logic [ROW_W-1:0] open_row,
    output logic             not_full,
    output logic             has_req,
    output logic [ROW_W-1:0] cand_row,
    output logic [TAG_W-1:0] cand_tag,
    output logic [TS_W-1:0]  cand_ts
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] vld_q;
    logic [ROW_W-1:0] row_q [DEPTH];
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [TS_W-1:0]  ts_q  [DEPTH];

    logic [IDX_W-1:0] free_idx, hit_idx, any_idx, cand_idx;
    logic             free_found, hit_found, any_found;

    // modular age compare: a arrived before b
    function automatic logic older(input logic [TS_W-1:0] a, input logic [TS_W-1:0] b);
        logic [TS_W-1:0] d;
        d = a - b;
        return d[TS_W-1];
    endfunction

    always_comb begin
        free_idx   = '0;
        free_found = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!vld_q[i] && !free_found) begin
                free_idx   = IDX_W'(i);
                free_found = 1'b1;
            end
        end
    end

    always_comb begin
        hit_idx   = '0;
        hit_found = 1'b0;
        any_idx   = '0;
        any_found = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld_q[i]) begin
                if (!any_found || older(ts_q[i], ts_q[any_idx])) begin
                    any_idx   = IDX_W'(i);
                    any_found = 1'b1;
                end
                if (open_vld && (row_q[i] == open_row) &&
                    (!hit_found || older(ts_q[i], ts_q[hit_idx]))) begin
                    hit_idx   = IDX_W'(i);
                    hit_found = 1'b1;
                end
            end
        end
    end

    assign cand_idx = hit_found ? hit_idx : any_idx;
    assign not_full = free_found;
    assign has_req  = any_found;
    assign cand_row = row_q[cand_idx];
    assign cand_tag = tag_q[cand_idx];
    assign cand_ts  = ts_q[cand_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (pop && has_req) vld_q[cand_idx] <= 1'b0;
            if (push && free_found) vld_q[free_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && free_found) begin
            row_q[free_idx] <= push_row;
            tag_q[free_idx] <= push_tag;
            ts_q[free_idx]  <= push_ts;
        end
    end
endmodule

// File: rtl/frs_write_fifo.sv
module frs_write_fifo #(
    parameter int DEPTH  = 8,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 8,
    parameter int TAG_W  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [BANK_W-1:0] push_bank,
    input  logic [ROW_W-1:0]  push_row,
    input  logic [TAG_W-1:0]  push_tag,
    input  logic              pop,
    output logic [CNT_W-1:0]  count,
    output logic [BANK_W-1:0] head_bank,
    output logic [ROW_W-1:0]  head_row,
    output logic [TAG_W-1:0]  head_tag
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [BANK_W-1:0] bank_q [DEPTH];
    logic [ROW_W-1:0]  row_q  [DEPTH];
    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [IDX_W-1:0]  rd_ptr, wr_ptr;
    logic              do_push, do_pop;

    assign do_push = push && (count != CNT_W'(DEPTH));
    assign do_pop  = pop && (count != '0);

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            bank_q[wr_ptr] <= push_bank;
            row_q[wr_ptr]  <= push_row;
            tag_q[wr_ptr]  <= push_tag;
        end
    end

    assign head_bank = bank_q[rd_ptr];
    assign head_row  = row_q[rd_ptr];
    assign head_tag  = tag_q[rd_ptr];
endmodule

// File: rtl/frs_age_pick.sv
module frs_age_pick #(
    parameter int N    = 4,
    parameter int TS_W = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]           req,
    input  logic [N-1:0][TS_W-1:0] ts,
    output logic [IDX_W-1:0]       win,
    output logic                   any
);
    logic [TS_W-1:0] diff;

    always_comb begin
        win  = '0;
        any  = 1'b0;
        diff = '0;
        for (int i = 0; i < N; i++) begin
            diff = ts[i] - ts[win];
            if (req[i] && (!any || diff[TS_W-1])) begin
                win = IDX_W'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/frfcfs_sched.sv
module frfcfs_sched
    import frs_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int RQ_DEPTH  = 4,
    parameter int WB_DEPTH  = 8,
    parameter int ROW_W     = 8,
    parameter int TAG_W     = 8,
    parameter int TS_W      = 16,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req_valid,
    input  logic [BANK_W-1:0] rd_req_bank,
    input  logic [ROW_W-1:0]  rd_req_row,
    input  logic [TAG_W-1:0]  rd_req_tag,
    output logic              rd_in_ready,
    input  logic              wr_req_valid,
    input  logic [BANK_W-1:0] wr_req_bank,
    input  logic [ROW_W-1:0]  wr_req_row,
    input  logic [TAG_W-1:0]  wr_req_tag,
    output logic              wr_in_ready,
    input  logic              issue_ready,
    output logic              issue_valid,
    output logic              issue_is_write,
    output logic [BANK_W-1:0] issue_bank,
    output logic [ROW_W-1:0]  issue_row,
    output logic [TAG_W-1:0]  issue_tag,
    output logic              issue_row_hit
);
    localparam int CNT_W = $clog2(WB_DEPTH + 1);

    sch_state_e state_q, state_d;
    logic [CNT_W-1:0] left_q, left_d;

    logic [NUM_BANKS-1:0]            bq_not_full, bq_has, bq_push, bq_pop;
    logic [NUM_BANKS-1:0][ROW_W-1:0] bq_row;
    logic [NUM_BANKS-1:0][TAG_W-1:0] bq_tag;
    logic [NUM_BANKS-1:0][TS_W-1:0]  bq_ts;
    logic [NUM_BANKS-1:0][ROW_W-1:0] open_row_q;
    logic [NUM_BANKS-1:0]            open_vld_q;

    logic [TS_W-1:0]   arr_ts_q;
    logic [BANK_W-1:0] win_bank;
    logic              rd_any, rd_accept, fire;
    logic [CNT_W-1:0]  wb_count;
    logic [BANK_W-1:0] wf_bank;
    logic [ROW_W-1:0]  wf_row;
    logic [TAG_W-1:0]  wf_tag;
    logic              wb_full, wb_empty, wb_push, wb_pop;

    assign wb_full     = (wb_count == CNT_W'(WB_DEPTH));
    assign wb_empty    = (wb_count == '0);
    assign rd_in_ready = bq_not_full[rd_req_bank];
    assign wr_in_ready = !wb_full;
    assign rd_accept   = rd_req_valid && rd_in_ready;
    assign wb_push     = wr_req_valid && wr_in_ready;
    assign fire        = issue_valid && issue_ready;
    assign wb_pop      = fire && issue_is_write;

    // arrival stamp for reads
    always_ff @(posedge clk) begin
        if (!rst_n)         arr_ts_q <= '0;
        else if (rd_accept) arr_ts_q <= arr_ts_q + 1'b1;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bq_push[b] = rd_accept && (rd_req_bank == BANK_W'(b));
        assign bq_pop[b]  = fire && !issue_is_write && (win_bank == BANK_W'(b));

        frs_bank_queue #(
            .DEPTH(RQ_DEPTH), .ROW_W(ROW_W), .TAG_W(TAG_W), .TS_W(TS_W)
        ) u_q (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (bq_push[b]),
            .push_row (rd_req_row),
            .push_tag (rd_req_tag),
            .push_ts  (arr_ts_q),
            .pop      (bq_pop[b]),
            .open_vld (open_vld_q[b]),
            .open_row (open_row_q[b]),
            .not_full (bq_not_full[b]),
            .has_req  (bq_has[b]),
            .cand_row (bq_row[b]),
            .cand_tag (bq_tag[b]),
            .cand_ts  (bq_ts[b])
        );
    end

    frs_age_pick #(.N(NUM_BANKS), .TS_W(TS_W)) u_pick (
        .req (bq_has),
        .ts  (bq_ts),
        .win (win_bank),
        .any (rd_any)
    );

    frs_write_fifo #(
        .DEPTH(WB_DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .TAG_W(TAG_W)
    ) u_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wb_push),
        .push_bank (wr_req_bank),
        .push_row  (wr_req_row),
        .push_tag  (wr_req_tag),
        .pop       (wb_pop),
        .count     (wb_count),
        .head_bank (wf_bank),
        .head_row  (wf_row),
        .head_tag  (wf_tag)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SCH_SERVE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    // selection and next state
    always_comb begin
        state_d        = state_q;
        left_d         = left_q;
        issue_valid    = 1'b0;
        issue_is_write = 1'b0;
        unique case (state_q)
            SCH_SERVE: begin
                if (wb_full) begin
                    issue_valid    = 1'b1;
                    issue_is_write = 1'b1;
                    state_d        = SCH_BATCH;
                    left_d         = CNT_W'(WB_DEPTH) - CNT_W'(issue_ready);
                end else if (rd_any) begin
                    issue_valid = 1'b1;
                end else if (!wb_empty) begin
                    issue_valid    = 1'b1;
                    issue_is_write = 1'b1;
                end
            end
            SCH_BATCH: begin
                issue_valid    = !wb_empty;
                issue_is_write = 1'b1;
                if (issue_valid && issue_ready) begin
                    left_d = left_q - 1'b1;
                    if (left_q == CNT_W'(1)) state_d = SCH_SERVE;
                end
            end
            default: ;
        endcase
    end

    assign issue_bank    = issue_is_write ? wf_bank : win_bank;
    assign issue_row     = issue_is_write ? wf_row  : bq_row[win_bank];
    assign issue_tag     = issue_is_write ? wf_tag  : bq_tag[win_bank];
    assign issue_row_hit = open_vld_q[issue_bank] && (open_row_q[issue_bank] == issue_row);

    // open-row tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_vld_q <= '0;
            open_row_q <= '0;
        end else if (fire) begin
            open_vld_q[issue_bank] <= 1'b1;
            open_row_q[issue_bank] <= issue_row;
        end
    end
endmodule

// File: rtl/frfcfs_sched_chk.sv
module frfcfs_sched_chk
    import frs_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int WB_DEPTH  = 8,
    parameter int ROW_W     = 8,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int CNT_W    = $clog2(WB_DEPTH + 1)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            issue_valid,
    input logic                            issue_ready,
    input logic                            issue_is_write,
    input logic [BANK_W-1:0]               issue_bank,
    input logic [ROW_W-1:0]                issue_row,
    input logic                            wr_req_valid,
    input logic                            wr_in_ready,
    input sch_state_e                      state_q,
    input logic [CNT_W-1:0]                wb_count,
    input logic                            rd_any,
    input logic [NUM_BANKS-1:0][ROW_W-1:0] open_row_q,
    input logic [NUM_BANKS-1:0]            open_vld_q
);
    assert_no_read_in_batch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SCH_BATCH) |-> (!issue_valid || issue_is_write));

    assert_full_enters_batch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SCH_SERVE && wb_count == CNT_W'(WB_DEPTH)) |=> (state_q == SCH_BATCH));

    assert_wb_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_valid && wr_in_ready && !(issue_valid && issue_ready && issue_is_write))
        |=> (wb_count == CNT_W'($past(wb_count) + 1'b1)));

    assert_work_conserving_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any || wb_count != '0) |-> issue_valid);

    assert_open_row_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_ready) |=>
        (open_vld_q[$past(issue_bank)] && open_row_q[$past(issue_bank)] == $past(issue_row)));

    assert_batch_ends_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state_q == SCH_BATCH) |-> $past(issue_valid && issue_ready && issue_is_write));
endmodule

bind frfcfs_sched frfcfs_sched_chk #(
    .NUM_BANKS(NUM_BANKS), .WB_DEPTH(WB_DEPTH), .ROW_W(ROW_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .issue_valid    (issue_valid),
    .issue_ready    (issue_ready),
    .issue_is_write (issue_is_write),
    .issue_bank     (issue_bank),
    .issue_row      (issue_row),
    .wr_req_valid   (wr_req_valid),
    .wr_in_ready    (wr_in_ready),
    .state_q        (state_q),
    .wb_count       (wb_count),
    .rd_any         (rd_any),
    .open_row_q     (open_row_q),
    .open_vld_q     (open_vld_q)
);

// File: tb/tb_frfcfs_sched.sv
module tb_frfcfs_sched;
    localparam int CLK_PERIOD = 10;
    localparam int NB     = 4;
    localparam int RQD    = 4;
    localparam int WBD    = 8;
    localparam int ROW_W  = 8;
    localparam int TAG_W  = 8;
    localparam int BANK_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_req_valid = 1'b0, wr_req_valid = 1'b0, issue_ready = 1'b0;
    logic [BANK_W-1:0] rd_req_bank = '0, wr_req_bank = '0;
    logic [ROW_W-1:0]  rd_req_row = '0, wr_req_row = '0;
    logic [TAG_W-1:0]  rd_req_tag = '0, wr_req_tag = '0;
    logic rd_in_ready, wr_in_ready, issue_valid, issue_is_write, issue_row_hit;
    logic [BANK_W-1:0] issue_bank;
    logic [ROW_W-1:0]  issue_row;
    logic [TAG_W-1:0]  issue_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    frfcfs_sched #(
        .NUM_BANKS(NB), .RQ_DEPTH(RQD), .WB_DEPTH(WBD), .ROW_W(ROW_W), .TAG_W(TAG_W)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .rd_req_valid(rd_req_valid), .rd_req_bank(rd_req_bank), .rd_req_row(rd_req_row),
        .rd_req_tag(rd_req_tag), .rd_in_ready(rd_in_ready),
        .wr_req_valid(wr_req_valid), .wr_req_bank(wr_req_bank), .wr_req_row(wr_req_row),
        .wr_req_tag(wr_req_tag), .wr_in_ready(wr_in_ready),
        .issue_ready(issue_ready), .issue_valid(issue_valid), .issue_is_write(issue_is_write),
        .issue_bank(issue_bank), .issue_row(issue_row), .issue_tag(issue_tag),
        .issue_row_hit(issue_row_hit)
    );

    typedef struct { int row; int tag; int ts; } rd_t;
    typedef struct { int bank; int row; int tag; } wr_t;

    rd_t rq [NB][$];
    wr_t wq [$];
    int  open_row [NB];
    bit  open_v [NB];
    bit  m_batch = 0;
    int  m_left = 0;
    int  m_ts = 0;
    int  rd_seq = 0, wr_seq = 0;
    bit  prev_stall = 0, prev_exit = 0;
    int  n_checks = 0, n_fail = 0;
    bit  done = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic one_cycle(input int p_rd, input int p_wr, input int p_rdy);
        bit e_valid, e_wr, e_hit, fire, pre_full, rd_acc, wr_acc, ex;
        int e_bank, e_row, e_tag, e_idx, best_b, best_i;
        string lbl;
        @(negedge clk);
        rd_req_valid = ($urandom_range(99) < p_rd);
        rd_req_bank  = BANK_W'($urandom_range(NB-1));
        rd_req_row   = ROW_W'($urandom_range(3));
        rd_req_tag   = TAG_W'(rd_seq);
        wr_req_valid = ($urandom_range(99) < p_wr);
        wr_req_bank  = BANK_W'($urandom_range(NB-1));
        wr_req_row   = ROW_W'($urandom_range(3));
        wr_req_tag   = TAG_W'(wr_seq);
        issue_ready  = ($urandom_range(99) < p_rdy);
        #1;
        // expected selection from the model
        e_valid = 0; e_wr = 0; e_bank = 0; e_row = 0; e_tag = 0; e_idx = -1;
        best_b = -1; best_i = -1;
        pre_full = (wq.size() == WBD);
        if (m_batch || pre_full) begin
            lbl = "R7";
            if (wq.size() > 0) begin e_valid = 1; e_wr = 1; end
        end else begin
            for (int b = 0; b < NB; b++) begin
                int hi, ai;
                hi = -1; ai = -1;
                for (int i = 0; i < rq[b].size(); i++) begin
                    if (ai < 0 || rq[b][i].ts < rq[b][ai].ts) ai = i;
                    if (open_v[b] && rq[b][i].row == open_row[b] &&
                        (hi < 0 || rq[b][i].ts < rq[b][hi].ts)) hi = i;
                end
                if (hi >= 0) ai = hi;
                if (ai >= 0 && (best_b < 0 || rq[b][ai].ts < rq[best_b][best_i].ts)) begin
                    best_b = b; best_i = ai;
                end
            end
            if (best_b >= 0) begin
                e_valid = 1; e_wr = 0;
                if (open_v[best_b] && rq[best_b][best_i].row == open_row[best_b]) lbl = "R3";
                else lbl = "R4";
                if (wq.size() > 0) lbl = "R5";
            end else if (wq.size() > 0) begin
                e_valid = 1; e_wr = 1; lbl = "R6";
            end else begin
                lbl = "R10";
            end
        end
        if (prev_exit) lbl = "R8";
        else if (prev_stall && lbl != "R7") lbl = "R10";
        if (e_valid && e_wr) begin
            e_bank = wq[0].bank; e_row = wq[0].row; e_tag = wq[0].tag;
        end else if (e_valid) begin
            e_bank = best_b; e_row = rq[best_b][best_i].row; e_tag = rq[best_b][best_i].tag;
        end
        e_hit = e_valid && open_v[e_bank] && open_row[e_bank] == e_row;

        chk(issue_valid == e_valid, lbl, "issue_valid", int'(issue_valid), int'(e_valid));
        if (e_valid && issue_valid) begin
            chk(issue_is_write == e_wr, lbl, "issue_is_write", int'(issue_is_write), int'(e_wr));
            chk(int'(issue_bank) == e_bank, lbl, "issue_bank", int'(issue_bank), e_bank);
            chk(int'(issue_row) == e_row, lbl, "issue_row", int'(issue_row), e_row);
            chk(int'(issue_tag) == e_tag, lbl, "issue_tag", int'(issue_tag), e_tag);
            chk(issue_row_hit == e_hit, "R9", "issue_row_hit", int'(issue_row_hit), int'(e_hit));
        end
        rd_acc = (rq[rd_req_bank].size() < RQD);
        wr_acc = (wq.size() < WBD);
        chk(rd_in_ready == rd_acc, "R2", "rd_in_ready", int'(rd_in_ready), int'(rd_acc));
        chk(wr_in_ready == wr_acc, "R2", "wr_in_ready", int'(wr_in_ready), int'(wr_acc));
        rd_acc = rd_acc && rd_req_valid;
        wr_acc = wr_acc && wr_req_valid;

        // model update for the coming edge
        fire = e_valid && issue_ready;
        if (fire) begin
            open_v[e_bank] = 1; open_row[e_bank] = e_row;
            if (e_wr) void'(wq.pop_front());
            else rq[best_b].delete(best_i);
        end
        ex = 0;
        if (!m_batch && pre_full) begin
            m_batch = 1; m_left = WBD - (fire ? 1 : 0);
        end else if (m_batch && fire) begin
            m_left--;
            if (m_left == 0) begin m_batch = 0; ex = 1; end
        end
        if (rd_acc) begin
            rq[rd_req_bank].push_back('{row: int'(rd_req_row), tag: int'(rd_req_tag), ts: m_ts});
            m_ts++; rd_seq++;
        end
        if (wr_acc) begin
            wq.push_back('{bank: int'(wr_req_bank), row: int'(wr_req_row), tag: int'(wr_req_tag)});
            wr_seq++;
        end
        prev_stall = e_valid && !issue_ready;
        prev_exit  = ex;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(issue_valid == 1'b0, "R1", "issue_valid in reset", int'(issue_valid), 0);
        chk(rd_in_ready == 1'b1, "R1", "rd_in_ready in reset", int'(rd_in_ready), 1);
        chk(wr_in_ready == 1'b1, "R1", "wr_in_ready in reset", int'(wr_in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(issue_valid == 1'b0, "R1", "issue_valid after reset", int'(issue_valid), 0);
        for (int b = 0; b < NB; b++) begin open_v[b] = 0; open_row[b] = 0; end
        for (int c = 0; c < 600; c++) one_cycle(60, 0, 70);   // reads only
        for (int c = 0; c < 800; c++) one_cycle(40, 40, 80);  // mixed
        for (int c = 0; c < 600; c++) one_cycle(30, 80, 50);  // write heavy
        for (int c = 0; c < 300; c++) one_cycle(0, 0, 100);   // drain
        for (int c = 0; c < 600; c++) one_cycle(45, 55, 30);  // stalling sink
        for (int c = 0; c < 300; c++) one_cycle(0, 0, 100);   // drain
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule